// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fast peripheral clock into a one-cycle enable pulse. The pulse repeats at sixteen times the serial bit rate. The transmit and receive engines of a UART advance their bit-sampling logic on each pulse. The base spacing between pulses is a 16-bit integer divisor, written one byte at a time.

A fractional correction stretches that spacing on average by the factor (1 + add/mul). An accumulator adds `add` at every pulse. Whenever the sum reaches `mul`, the next interval is lengthened by one whole divisor period, and `mul` is subtracted from the sum. The resulting bit rate is clk / (16 × divisor × (1 + add/mul)).

Software programs the block through a small byte-wide write port with four addresses:

| Address | Register | Contents |
|---|---|---|
| 0 | Divisor low byte | Bits 7:0 of the divisor |
| 1 | Divisor high byte | Bits 15:8 of the divisor |
| 2 | Control | Bit 7 is the unlock bit |
| 3 | Fraction | Bits 3:0 hold `add`, bits 7:4 hold `mul` |

A divisor byte write is accepted only while the unlock bit is 1.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted, `tick` is 0. Reset leaves the divisor at 1, the unlock bit at 0, and `add` and `mul` at 0. From the first clock edge after reset is released, `tick` is therefore 1 on every cycle.
- R2: With the fractional path inactive, consecutive ticks are exactly D = 256 × high byte + low byte cycles apart.
- R3: A write to address 0 or 1 while the unlock bit (bit 7 of address 2) is 0 changes neither the divisor nor the tick spacing.
- R4: A divisor of 0 behaves exactly like a divisor of 1, so a tick occurs every cycle.
- R5: With the fractional path active, the first interval after a restart is D cycles. The interval that follows the n-th tick (n ≥ 1) is D × (1 + floor(n·add/mul) − floor((n−1)·add/mul)).
- R6: A stored `mul` of 0 is taken as 1. The fractional path is active only when `add` is non-zero and `add` is less than the effective `mul`; otherwise ticks are purely integer-spaced.
- R7: An accepted divisor byte write restarts the timing. No tick occurs in the write's cycle, the first tick comes exactly D cycles later, and the accumulator is cleared.
- R8: When D ≥ 2, every tick lasts exactly one cycle.
- R9: A write to the fraction register (address 3) clears the accumulator without restarting the current interval. The interval after the next tick then follows R5 with n = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Register address: 0 divisor low, 1 divisor high, 2 control, 3 fraction |
| wr_data | input | 8 | Register write data |
| tick | output | 1 | Single-cycle enable at 16 × baud |

## Verification
The assertions assume that `wr_en` is a clean single-cycle strobe with a defined address and data. They also assume that the fraction fields change only through address 3, which is why a fraction write must clear the accumulator to keep it below the effective `mul`.

The stimulus keeps within these limits. Every write is driven for exactly one cycle, away from the clock edge, through one bench task. Random divisors, `add` values and `mul` values, including zeros and values where `add` ≥ `mul`, all enter through that same task.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int BYTE_W  = 8;
  localparam int DIV_W   = 2 * BYTE_W;
  localparam int CNT_W   = DIV_W + 1;
  localparam int FRAC_W  = 4;
  localparam int MUL_LSB = 4;
  localparam int ADR_W   = 2;
  localparam int UNLOCK_BIT = 7;

  localparam logic [ADR_W-1:0] ADR_DIV_LO = 2'd0;
  localparam logic [ADR_W-1:0] ADR_DIV_HI = 2'd1;
  localparam logic [ADR_W-1:0] ADR_CTRL   = 2'd2;
  localparam logic [ADR_W-1:0] ADR_FRAC   = 2'd3;

  typedef logic [DIV_W-1:0]  div_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [FRAC_W-1:0] frac_t;

  // zero divisor is run as one so the tick never stalls
  function automatic div_t eff_div(input div_t d);
    return (d == '0) ? div_t'(1) : d;
  endfunction

  function automatic frac_t eff_mul(input frac_t m);
    return (m == '0) ? frac_t'(1) : m;
  endfunction

  function automatic logic frac_on(input frac_t a, input frac_t m);
    return (a != '0) && (a < eff_mul(m));
  endfunction
endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output div_t             divisor,
  output div_t             div_next,
  output logic             div_load,
  output frac_t            frac_add,
  output frac_t            frac_mul,
  output logic             frac_load
);
  logic              unlock_q;
  logic [BYTE_W-1:0] lo_q, hi_q;
  logic              lo_wr, hi_wr;

  assign lo_wr     = wr_en && unlock_q && (wr_addr == ADR_DIV_LO);
  assign hi_wr     = wr_en && unlock_q && (wr_addr == ADR_DIV_HI);
  assign div_load  = lo_wr || hi_wr;
  assign frac_load = wr_en && (wr_addr == ADR_FRAC);

  assign divisor  = {hi_q, lo_q};
  assign div_next = {hi_wr ? wr_data : hi_q, lo_wr ? wr_data : lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q     <= BYTE_W'(1);
      hi_q     <= '0;
      unlock_q <= 1'b0;
      frac_add <= '0;
      frac_mul <= '0;
    end else begin
      if (lo_wr) lo_q <= wr_data;
      if (hi_wr) hi_q <= wr_data;
      if (wr_en && wr_addr == ADR_CTRL) unlock_q <= wr_data[UNLOCK_BIT];
      if (frac_load) begin
        frac_add <= wr_data[FRAC_W-1:0];
        frac_mul <= wr_data[MUL_LSB +: FRAC_W];
      end
    end
  end

  // R3: locked divisor bytes ignore writes
  a_r3_locked_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlock_q && (wr_addr == ADR_DIV_LO || wr_addr == ADR_DIV_HI))
      |=> $stable(divisor));
endmodule

// File: rtl/baud_frac.sv
module baud_frac
  import baud_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  period_end,
  input  logic  clear,
  input  frac_t add,
  input  frac_t mul,
  output logic  stretch
);
  frac_t             acc_q;
  logic [FRAC_W:0]   sum;
  logic              active;
  logic              wrap;

  assign active  = frac_on(add, mul);
  assign sum     = {1'b0, acc_q} + {1'b0, add};
  assign wrap    = active && (sum >= {1'b0, eff_mul(mul)});
  assign stretch = period_end && wrap && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   acc_q <= '0;
    else if (clear)               acc_q <= '0;
    else if (period_end && active)
      acc_q <= wrap ? FRAC_W'(sum - {1'b0, eff_mul(mul)}) : FRAC_W'(sum);
  end

  // R5: accumulator stays below the effective multiplier
  a_r5_acc_below_mul: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (acc_q < eff_mul(mul)));
  // R6: inactive fraction never stretches
  a_r6_no_stretch_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !stretch);
endmodule

// File: rtl/baud_counter.sv
module baud_counter
  import baud_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  div_t divisor,
  input  div_t div_next,
  input  logic div_load,
  input  logic stretch,
  output logic period_end,
  output logic tick
);
  cnt_t cnt_q;
  div_t d_eff;
  cnt_t len;

  assign d_eff      = eff_div(divisor);
  assign len        = stretch ? {d_eff, 1'b0} : {1'b0, d_eff};
  assign period_end = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= period_end && !div_load;
      if (div_load)        cnt_q <= {1'b0, eff_div(div_next)} - cnt_t'(1);
      else if (period_end) cnt_q <= len - cnt_t'(1);
      else                 cnt_q <= cnt_q - cnt_t'(1);
    end
  end

  // R7: divisor write restarts the count and suppresses the tick
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    div_load |=> (!tick && cnt_q == ({1'b0, eff_div(divisor)} - cnt_t'(1))));
  // R8: single-cycle pulse for divisors of two or more
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && d_eff >= div_t'(2)) |=> !tick);
  // R2: count never exceeds a doubled period
  a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < {d_eff, 1'b0});
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADR_W-1:0]  wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              tick
);
  div_t  divisor, div_next;
  logic  div_load, frac_load;
  frac_t frac_add, frac_mul;
  logic  period_end, stretch;

  baud_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .divisor(divisor), .div_next(div_next), .div_load(div_load),
    .frac_add(frac_add), .frac_mul(frac_mul), .frac_load(frac_load)
  );

  baud_frac u_frac (
    .clk(clk), .rst_n(rst_n), .period_end(period_end),
    .clear(frac_load || div_load), .add(frac_add), .mul(frac_mul),
    .stretch(stretch)
  );

  baud_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .div_next(div_next),
    .div_load(div_load), .stretch(stretch), .period_end(period_end), .tick(tick)
  );

  // R1: no tick while held in reset
  always_comb begin
    if (!rst_n) a_r1_reset_quiet: assert (!tick || $time == 0);
  end
endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick(tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // number of extra divisor periods after the n-th tick (R5, R6)
  function automatic int extra(input int n, input int a, input int m);
    int me;
    me = (m == 0) ? 1 : m;
    if (a == 0 || a >= me) return 0;
    return (n * a) / me - ((n - 1) * a) / me;
  endfunction

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(addr); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_div(input int d);
    wr(2, 8'h80);
    wr(0, d & 8'hFF);
    wr(1, (d >> 8) & 8'hFF);
  endtask

  // measure tick gaps; from_write: just after the restarting write
  task automatic run_ticks(input string req, input int d, input int a, input int m,
                           input int nticks, input bit from_write);
    int n, seen, last, limit, gap, exp;
    bit found;
    seen = 0; last = 0;
    limit = 2 * eff(d) * (nticks + 1) + 4;
    if (from_write) begin
      n = 0;
      check(tick == 1'b0, "R7", int'(tick), 0);
    end else begin
      n = 1;
      found = 0;
      for (int k = 0; k < 4 * eff(d) + 4 && !found; k++) begin
        @(negedge clk);
        if (tick) found = 1;
      end
      check(found, req, int'(found), 1);
    end
    for (int j = 1; j <= limit && seen < nticks; j++) begin
      @(negedge clk);
      if (tick) begin
        gap = j - last;
        exp = (n == 0) ? eff(d) : eff(d) * (1 + extra(n, a, m));
        check(gap == exp, req, gap, exp);
        n++; seen++; last = j;
      end
    end
    if (seen < nticks) check(0, req, seen, nticks);
  endtask

  initial begin
    void'($urandom(32'h5EED1));
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      check(tick == 1'b0, "R1", int'(tick), 0);
    end
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(tick == 1'b1, "R1", int'(tick), 1);
    end

    // R2 / R7: integer spacing
    set_div(5);    run_ticks("R2", 5, 0, 0, 5, 1);
    set_div(259);  run_ticks("R2", 259, 0, 0, 3, 1);
    // R4: zero divisor acts as one
    set_div(0);    run_ticks("R4", 0, 0, 0, 4, 1);
    // R5: fractional stretch
    wr(3, 8'h73);
    set_div(4);    run_ticks("R5", 4, 3, 7, 8, 1);
    // R6: mul 0 and add == mul keep integer spacing
    wr(3, 8'h05);
    set_div(3);    run_ticks("R6", 3, 5, 0, 4, 1);
    wr(3, 8'h55);
    set_div(3);    run_ticks("R6", 3, 5, 5, 4, 1);
    // R3: locked divisor writes have no effect
    wr(3, 8'h00);
    set_div(6);
    wr(2, 8'h00);
    wr(0, 2);
    wr(1, 1);
    run_ticks("R3", 6, 0, 0, 3, 0);
    // R9: fraction write clears accumulator, interval continues
    wr(2, 8'h80);
    wr(3, 8'h52);
    set_div(7);
    repeat (23) @(negedge clk);
    wr(3, 8'h52);
    run_ticks("R9", 7, 2, 5, 6, 0);
    // R5 / R8: random mixes
    for (int t = 0; t < 25; t++) begin
      int d, a, m;
      d = int'($urandom_range(1, 24));
      a = int'($urandom_range(0, 15));
      m = int'($urandom_range(0, 15));
      wr(3, (m << 4) | a);
      set_div(d);
      run_ticks("R5", d, a, m, 10, 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule